// File: doc/BRIEF.md
# Parallel Host Port Bridge

This block is a 16-bit asynchronous slave port through which an external processor reaches a word-addressed on-chip memory and trades short messages with a local CPU. The external side uses active-low chip select, read strobe and write strobe, a two-bit register select and a 16-bit data bus. The bus is split into input, output and output-enable so that the pad ring can build the bidirectional pins. Four registers sit behind the select lines: a memory window, a mailbox, an address pointer and a status word.

Memory is reached indirectly. The host loads the pointer, then reads or writes the window register repeatedly. After every window access the pointer steps by one word, so a block transfer needs only one pointer write. On the core side the block drives a synchronous memory request port. It also prefetches the word under the pointer, so that a read strobe can be answered from a local holding register.

Messages flow in both directions. A host message is held for the local CPU and flagged until the CPU consumes it. A CPU message raises an interrupt line toward the host, and that line stays high until the host reads the mailbox. An optional swap input exchanges the two bytes of every word that passes between the bus and memory.

Top module: `hostport_bridge`

## Requirements
- R1: After reset, `host_irq`, `ext_data_oe`, `cpu_in_full` and `mem_we` are low, and a host read of the status register returns 0.
- R2: Register select code 00 is the memory window, 01 the mailbox, 10 the address pointer and 11 the status word. A pointer write keeps the low ADDR_W bits, and a pointer read returns them zero-extended to 16 bits.
- R3: A host access takes effect only when its strobe returns high after having been low together with chip select. While the strobe is held low, nothing is committed. A strobe pulse with chip select high has no effect.
- R4: A window write stores the bus word at the pointer address. Every window read or write then advances the pointer by one, wrapping modulo 2^ADDR_W.
- R5: A window read returns the memory word at the current pointer, so consecutive reads return consecutive words.
- R6: With `swap_en` high, bits [15:8] and [7:0] are exchanged on words written to memory and on words read from memory through the window. With `swap_en` low, words pass unchanged.
- R7: A host mailbox write makes the word visible on `cpu_mb_rdata` and sets `cpu_in_full` (status bit 0). The flag stays set until a `cpu_mb_rd` pulse clears it.
- R8: A `cpu_mb_wr` pulse loads the outgoing message, sets status bit 1 and raises `host_irq`. A host mailbox read returns that message and clears both the flag and `host_irq`.
- R9: Host writes to the status register change nothing, and status bits [15:2] always read 0.
- R10: `ext_data_oe` is high only while the synchronized chip select and read strobe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cs_n | input | 1 | Host chip select, active low |
| ext_rd_n | input | 1 | Host read strobe, active low |
| ext_wr_n | input | 1 | Host write strobe, active low |
| ext_addr | input | 2 | Host register select |
| ext_data_in | input | 16 | Host bus, write direction |
| ext_data_out | output | 16 | Host bus, read direction |
| ext_data_oe | output | 1 | Drive enable for the host bus |
| host_irq | output | 1 | Outgoing message pending |
| swap_en | input | 1 | Byte exchange on window traffic |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Memory write word |
| mem_rdata | input | 16 | Memory read word, valid the cycle after a read request |
| cpu_mb_wr | input | 1 | Local CPU writes outgoing message |
| cpu_mb_wdata | input | 16 | Outgoing message word |
| cpu_mb_rd | input | 1 | Local CPU consumes incoming message |
| cpu_mb_rdata | output | 16 | Incoming message word |
| cpu_in_full | output | 1 | Incoming message waiting |

## Verification
The memory window is swept with a full ring of distinct, arithmetically generated words. The sweep starts at a nonzero pointer, so both the pointer step and its wraparound are exercised, and a wrong increment or an off-by-one prefetch shows up as a mismatched word. Byte swapping is tried with swap on for both directions and then mixed, which tells a swap applied once from one applied twice or not at all. The mailbox is driven with several message values in both directions, including an overwrite before consumption. Strobes with chip select high, status writes and held strobes show that nothing is committed outside a completed access.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  typedef enum logic [1:0] {
    SEL_WINDOW = 2'b00,
    SEL_MBOX   = 2'b01,
    SEL_PTR    = 2'b10,
    SEL_STATUS = 2'b11
  } sel_e;

  function automatic logic [15:0] swap16(input logic [15:0] w, input logic en);
    return en ? {w[7:0], w[15:8]} : w;
  endfunction

  function automatic logic [15:0] pack_status(input logic in_full, input logic out_full);
    return {14'd0, out_full, in_full};
  endfunction

endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= RST_VAL[i];
        st2 <= RST_VAL[i];
      end else begin
        st1 <= d[i];
        st2 <= st1;
      end
    end
    assign q[i] = st2;
  end
endmodule

// File: rtl/hpb_window.sv
module hpb_window #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_load,
  input  logic [15:0]       ptr_value,
  input  logic              win_wr_done,
  input  logic              win_rd_done,
  input  logic [15:0]       win_wdata,
  input  logic              swap_en,
  output logic [ADDR_W-1:0] ptr,
  output logic [15:0]       win_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  import hpb_pkg::*;

  localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

  logic              data_done;
  logic              fetch_q;
  logic              land_q;
  logic [15:0]       hold_q;

  function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p);
    return p + PTR_ONE;
  endfunction

  assign data_done = win_wr_done | win_rd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      fetch_q <= 1'b1;
      land_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      if (ptr_load)       ptr <= ptr_value[ADDR_W-1:0];
      else if (data_done) ptr <= step_ptr(ptr);
      fetch_q <= ptr_load | data_done;
      land_q  <= fetch_q & ~win_wr_done;
      if (land_q) hold_q <= mem_rdata;
    end
  end

  assign mem_req   = win_wr_done | fetch_q;
  assign mem_we    = win_wr_done;
  assign mem_addr  = ptr;
  assign mem_wdata = swap16(win_wdata, swap_en);
  assign win_rdata = swap16(hold_q, swap_en);

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && !ptr_load) |=> ptr == $past(ptr) + PTR_ONE);

  assert_prefetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && !ptr_load) |=> (mem_req && !mem_we && mem_addr == $past(ptr) + PTR_ONE));

  assert_load_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_load |=> ptr == $past(ptr_value[ADDR_W-1:0]));

endmodule

// File: rtl/hpb_mailbox.sv
module hpb_mailbox (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  input  logic        host_rd,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_wdata,
  input  logic        cpu_rd,
  output logic [15:0] to_cpu,
  output logic [15:0] to_host,
  output logic        in_full,
  output logic        out_full
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_cpu   <= '0;
      to_host  <= '0;
      in_full  <= 1'b0;
      out_full <= 1'b0;
    end else begin
      if (host_wr) begin
        to_cpu  <= host_wdata;
        in_full <= 1'b1;
      end else if (cpu_rd) begin
        in_full <= 1'b0;
      end
      if (cpu_wr) begin
        to_host  <= cpu_wdata;
        out_full <= 1'b1;
      end else if (host_rd) begin
        out_full <= 1'b0;
      end
    end
  end

  assert_in_full_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (in_full && to_cpu == $past(host_wdata)));

  assert_in_full_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !host_wr) |=> !in_full);

  assert_out_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_full) |-> $past(cpu_wr));

  assert_out_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !cpu_wr) |=> !out_full);

endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_cs_n,
  input  logic              ext_rd_n,
  input  logic              ext_wr_n,
  input  logic [1:0]        ext_addr,
  input  logic [15:0]       ext_data_in,
  output logic [15:0]       ext_data_out,
  output logic              ext_data_oe,
  output logic              host_irq,
  input  logic              swap_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  input  logic              cpu_mb_wr,
  input  logic [15:0]       cpu_mb_wdata,
  input  logic              cpu_mb_rd,
  output logic [15:0]       cpu_mb_rdata,
  output logic              cpu_in_full
);
  import hpb_pkg::*;

  logic [2:0]        strobe_s;
  logic              s_cs_n, s_rd_n, s_wr_n;
  logic              rd_act, wr_act, rd_act_q, wr_act_q;
  logic              rd_done, wr_done;
  logic [1:0]        wr_sel_q, rd_sel_q;
  logic [15:0]       wr_word_q;
  logic [15:0]       rd_word_q;
  logic [ADDR_W-1:0] ptr;
  logic [15:0]       win_rdata;
  logic [15:0]       mbox_to_host;
  logic              in_full, out_full;

  logic              win_wr_done, win_rd_done, ptr_load, mb_wr_done, mb_rd_done;

  hpb_sync #(.WIDTH(3), .RST_VAL(3'b111)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ext_cs_n, ext_rd_n, ext_wr_n}),
    .q    (strobe_s)
  );
  assign {s_cs_n, s_rd_n, s_wr_n} = strobe_s;

  assign rd_act  = ~s_cs_n & ~s_rd_n;
  assign wr_act  = ~s_cs_n & ~s_wr_n;
  assign rd_done = rd_act_q & ~rd_act;
  assign wr_done = wr_act_q & ~wr_act;

  assign win_wr_done = wr_done && wr_sel_q == SEL_WINDOW;
  assign mb_wr_done  = wr_done && wr_sel_q == SEL_MBOX;
  assign ptr_load    = wr_done && wr_sel_q == SEL_PTR;
  assign win_rd_done = rd_done && rd_sel_q == SEL_WINDOW;
  assign mb_rd_done  = rd_done && rd_sel_q == SEL_MBOX;

  function automatic logic [15:0] pick_read(input logic [1:0] sel,
                                            input logic [15:0] win,
                                            input logic [15:0] mb,
                                            input logic [ADDR_W-1:0] p,
                                            input logic inf, input logic outf);
    case (sel)
      SEL_WINDOW: return win;
      SEL_MBOX:   return mb;
      SEL_PTR:    return 16'(p);
      default:    return pack_status(inf, outf);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q  <= 1'b0;
      wr_act_q  <= 1'b0;
      wr_sel_q  <= '0;
      rd_sel_q  <= '0;
      wr_word_q <= '0;
      rd_word_q <= '0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      if (wr_act) begin
        wr_sel_q  <= ext_addr;
        wr_word_q <= ext_data_in;
      end
      if (rd_act) rd_sel_q <= ext_addr;
      rd_word_q <= pick_read(ext_addr, win_rdata, mbox_to_host, ptr, in_full, out_full);
    end
  end

  hpb_window #(.ADDR_W(ADDR_W)) i_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_load   (ptr_load),
    .ptr_value  (wr_word_q),
    .win_wr_done(win_wr_done),
    .win_rd_done(win_rd_done),
    .win_wdata  (wr_word_q),
    .swap_en    (swap_en),
    .ptr        (ptr),
    .win_rdata  (win_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata)
  );

  hpb_mailbox i_mailbox (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (mb_wr_done),
    .host_wdata(wr_word_q),
    .host_rd   (mb_rd_done),
    .cpu_wr    (cpu_mb_wr),
    .cpu_wdata (cpu_mb_wdata),
    .cpu_rd    (cpu_mb_rd),
    .to_cpu    (cpu_mb_rdata),
    .to_host   (mbox_to_host),
    .in_full   (in_full),
    .out_full  (out_full)
  );

  assign ext_data_out = rd_word_q;
  assign ext_data_oe  = rd_act;
  assign host_irq     = out_full;
  assign cpu_in_full  = in_full;

  assert_oe_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_data_oe |-> ($past(!ext_cs_n, 2) && $past(!ext_rd_n, 2)));

  assert_commit_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(wr_act) && !wr_act));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(cpu_mb_wr));

endmodule

// File: tb/test_hostport_bridge.sv
module test_hostport_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'b00;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic oe, irq;
  logic swap = 1'b0;
  logic mreq, mwe;
  logic [AW-1:0] maddr;
  logic [15:0] mwdata;
  logic [15:0] mrdata = '0;
  logic cwr = 1'b0, crd = 1'b0;
  logic [15:0] cwdata = '0;
  logic [15:0] crdata;
  logic cfull;

  int total = 0;
  int bad = 0;
  int wr_count = 0;
  logic [15:0] mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  hostport_bridge #(.ADDR_W(AW)) i_hostport_bridge (
    .clk(clk), .rst_n(rst_n), .ext_cs_n(cs_n), .ext_rd_n(rd_n), .ext_wr_n(wr_n),
    .ext_addr(addr), .ext_data_in(din), .ext_data_out(dout), .ext_data_oe(oe),
    .host_irq(irq), .swap_en(swap), .mem_req(mreq), .mem_we(mwe), .mem_addr(maddr),
    .mem_wdata(mwdata), .mem_rdata(mrdata), .cpu_mb_wr(cwr), .cpu_mb_wdata(cwdata),
    .cpu_mb_rd(crd), .cpu_mb_rdata(crdata), .cpu_in_full(cfull)
  );

  always_ff @(posedge clk) begin
    if (mreq && mwe) begin
      mem[maddr] <= mwdata;
      wr_count   <= wr_count + 1;
    end
    if (mreq && !mwe) mrdata <= mem[maddr];
  end

  function automatic logic [15:0] pattern(input int i);
    return 16'((i * 16'h1357) ^ 16'hA5C3);
  endfunction

  function automatic logic [15:0] bswap(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; din = d; cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic hread(input logic [1:0] a, output logic [15:0] q);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    q = dout;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [15:0] d);
    @(negedge clk); cwr = 1'b1; cwdata = d;
    @(negedge clk); cwr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cpu_read();
    @(negedge clk); crd = 1'b1;
    @(negedge clk); crd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd1, 16'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] q;
    int base;
    for (int i = 0; i < DEPTH; i++) mem[i] = 16'hDEAD;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 oe", {15'd0, oe}, 16'd0);
    check("R1 in_full", {15'd0, cfull}, 16'd0);
    check("R1 mem_we", {15'd0, mwe}, 16'd0);
    hread(2'b11, q); check("R1 status", q, 16'd0);

    // R10 no drive without chip select
    @(negedge clk); rd_n = 1'b0; addr = 2'b11;
    repeat (5) @(negedge clk);
    check("R10 oe cs high", {15'd0, oe}, 16'd0);
    cs_n = 1'b0; repeat (4) @(negedge clk);
    check("R10 oe cs low", {15'd0, oe}, 16'd1);
    rd_n = 1'b1; cs_n = 1'b1; repeat (6) @(negedge clk);

    // R2 pointer register, zero extended
    hwrite(2'b10, 16'hFFFB);
    hread(2'b10, q); check("R2 ptr readback", q, 16'h000B);

    // R3 strobe with chip select high ignored
    base = wr_count;
    @(negedge clk); addr = 2'b00; din = 16'h1111; wr_n = 1'b0;
    repeat (4) @(negedge clk); wr_n = 1'b1; repeat (6) @(negedge clk);
    check("R3 no write without cs", 16'(wr_count - base), 16'd0);
    hread(2'b10, q); check("R3 ptr unchanged", q, 16'h000B);

    // R3 nothing committed while strobe held low
    @(negedge clk); addr = 2'b00; din = 16'h2222; cs_n = 1'b0; wr_n = 1'b0;
    repeat (8) @(negedge clk);
    check("R3 held strobe", 16'(wr_count - base), 16'd0);
    wr_n = 1'b1; cs_n = 1'b1; repeat (6) @(negedge clk);
    check("R3 commit on release", 16'(wr_count - base), 16'd1);
    check("R4 word at ptr", mem[11], 16'h2222);
    hread(2'b10, q); check("R4 ptr advanced", q, 16'h000C);

    // R4 full ring write from ptr 5 with wrap
    hwrite(2'b10, 16'd5);
    for (int i = 0; i < DEPTH; i++) hwrite(2'b00, pattern(i));
    for (int i = 0; i < DEPTH; i++) check("R4 ring store", mem[(5 + i) % DEPTH], pattern(i));
    hread(2'b10, q); check("R4 wrap ptr", q, 16'd5);

    // R5 sequential reads
    for (int i = 0; i < DEPTH; i++) begin
      hread(2'b00, q); check("R5 ring read", q, pattern(i));
    end
    hread(2'b10, q); check("R5 ptr after reads", q, 16'd5);

    // R6 swap on write and read
    swap = 1'b1;
    hwrite(2'b10, 16'd2);
    for (int i = 0; i < 4; i++) hwrite(2'b00, pattern(40 + i));
    for (int i = 0; i < 4; i++) check("R6 swapped store", mem[2 + i], bswap(pattern(40 + i)));
    hwrite(2'b10, 16'd2);
    for (int i = 0; i < 4; i++) begin
      hread(2'b00, q); check("R6 swap round trip", q, pattern(40 + i));
    end
    swap = 1'b0;
    hwrite(2'b10, 16'd2);
    for (int i = 0; i < 4; i++) begin
      hread(2'b00, q); check("R6 raw read", q, bswap(pattern(40 + i)));
    end

    // R7 host to CPU messages
    for (int i = 0; i < 4; i++) begin
      hwrite(2'b01, pattern(70 + i));
      check("R7 cpu data", crdata, pattern(70 + i));
      check("R7 in_full", {15'd0, cfull}, 16'd1);
      hread(2'b11, q); check("R7 status bit0", q, 16'h0001);
      cpu_read();
      check("R7 cleared", {15'd0, cfull}, 16'd0);
    end
    hwrite(2'b01, 16'h0A0A); hwrite(2'b01, 16'h0B0B);
    check("R7 overwrite", crdata, 16'h0B0B);
    hread(2'b11, q); check("R7 still full", q, 16'h0001);
    cpu_read();

    // R8 CPU to host messages
    for (int i = 0; i < 4; i++) begin
      cpu_write(pattern(90 + i));
      check("R8 irq high", {15'd0, irq}, 16'd1);
      hread(2'b11, q); check("R8 status bit1", q, 16'h0002);
      check("R8 irq kept by status read", {15'd0, irq}, 16'd1);
      hread(2'b01, q); check("R8 message", q, pattern(90 + i));
      check("R8 irq cleared", {15'd0, irq}, 16'd0);
      hread(2'b11, q); check("R8 status clear", q, 16'h0000);
    end

    // R9 status writes ignored
    hwrite(2'b11, 16'hFFFF);
    hread(2'b11, q); check("R9 status write idle", q, 16'h0000);
    check("R9 irq idle", {15'd0, irq}, 16'd0);
    cpu_write(16'h5A5A);
    hwrite(2'b11, 16'h0000);
    hread(2'b11, q); check("R9 status write full", q, 16'h0002);
    check("R9 irq kept", {15'd0, irq}, 16'd1);
    hread(2'b01, q); check("R9 message intact", q, 16'h5A5A);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule